// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog counter that software must service through a single 32-bit control word. Each write to that word carries three things: a 7-bit key, a run command and an 8-bit reload count. While the watchdog is armed, a write is honoured only if its key is the bitwise inverse of the key that was last accepted. Software therefore has to alternate between a key and its complement. A stray or replayed write cannot keep the watchdog alive.

An accepted write reloads the counter and either starts or stops it. The counter steps down once per pulse on a slow tick-enable input, which nominally runs at about 760 Hz.

The watchdog escalates in two stages. On the first expiry it raises a non-maskable interrupt and reloads a short grace count. If that grace count also runs out before an accepted write arrives, the block emits a one-cycle system reset request and stops counting. A status word exposes the live count, the running flag and the interrupt-pending flag. A second output reads back the stored control word.

Top module: `wdk_top`

## Requirements
- R1: A synchronous reset clears the stored control word, the count, the running flag, the interrupt and the reset request, so `stat_o` and `ctrl_o` read 0.
- R2: When bit 8 of the stored control word is 0, every write is accepted whatever its key in bits [15:9].
- R3: When bit 8 of the stored control word is 1, a write whose bits [15:9] differ from the inverse of the stored bits [15:9] is ignored: count, flags and stored word all keep their values.
- R4: An accepted write loads the count from bits [7:0], and a field of 0 loads 256. The whole written word becomes the stored control word.
- R5: An accepted write with bit 8 clear stops the counter. While stopped, ticks leave the count unchanged.
- R6: While running, the count drops by exactly one in each cycle that `tick_en` is high. It holds in cycles where `tick_en` is low.
- R7: A tick at count 1 with no earlier expiry raises `nmi_o` and reloads the count with GRACE (default 1). The counter keeps running.
- R8: A tick at count 1 while `nmi_o` is already high drives `rst_req_o` high for exactly one cycle. It also clears the running flag and leaves the count at 0.
- R9: An accepted write clears `nmi_o` and the expiry history, so the next expiry is treated as a first one again.
- R10: When an accepted write and a tick land in the same cycle, the write takes effect and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable from the slow tick source |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: [7:0] count, [8] run, [15:9] key |
| stat_o | output | 11 | {nmi pending, running, count[8:0]} |
| ctrl_o | output | 32 | Stored control word |
| nmi_o | output | 1 | Non-maskable interrupt, held until an accepted write |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest condition to reach from the ports is the second expiry. To get there, the bench needs an accepted write with a correctly alternated key, then enough ticks to drain the count, then further ticks through the grace reload, all with no accepted write in between. The stimulus therefore walks the key chain and drains the count one tick at a time. It checks every cycle of the escalation, including the cycle after the reset pulse. A separate sequence lines up a correctly keyed write with a tick in the same cycle while the interrupt is pending. This exercises both the write-wins ordering and the clearing of the escalation history.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no expiry since the last accepted write
    ST_WARN  = 2'd1,  // interrupt raised, grace count running
    ST_FIRED = 2'd2   // reset requested, counter halted
  } wdk_stage_e;
endpackage

// File: rtl/wdk_keygate.sv
module wdk_keygate #(
  parameter int CTRL_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              accept,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int EN_BIT  = CNT_W;
  localparam int KEY_LSB = CNT_W + 1;

  logic key_ok;

  // The new key must be the inverse of the stored key while armed.
  always_comb begin
    key_ok = (wr_data[KEY_LSB +: KEY_W] == ~ctrl_q[KEY_LSB +: KEY_W]);
    accept = wr_en && (!ctrl_q[EN_BIT] || key_ok);
  end

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 8,
  parameter int GRACE = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [CNT_W-1:0] load_field,
  input  logic           load_run,
  input  logic           tick_en,
  input  logic           grace_ld,
  input  logic           halt,
  output logic [CNT_W:0] cnt_q,
  output logic           run_q,
  output logic           expire
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE);
  localparam logic [CW-1:0] ONE_V   = CW'(1);

  logic [CW-1:0] load_val;

  always_comb begin
    // A zero field selects the full 2**CNT_W span.
    if (load_field == '0) load_val = {1'b1, {CNT_W{1'b0}}};
    else                  load_val = {1'b0, load_field};
    expire = run_q && tick_en && !load && (cnt_q == ONE_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= load_run;
    end else if (expire) begin
      if (grace_ld) begin
        cnt_q <= GRACE_V;
      end else if (halt) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (run_q && tick_en) begin
      cnt_q <= cnt_q - ONE_V;
    end
  end
endmodule

// File: rtl/wdk_escalate.sv
module wdk_escalate
  import wdk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic expire,
  output logic grace_ld,
  output logic halt,
  output logic nmi_q,
  output logic rst_req_q
);
  wdk_stage_e stage_q;

  always_comb begin
    grace_ld = expire && (stage_q == ST_IDLE);
    halt     = expire && (stage_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= ST_IDLE;
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (clear) begin
        stage_q <= ST_IDLE;
        nmi_q   <= 1'b0;
      end else if (grace_ld) begin
        stage_q <= ST_WARN;
        nmi_q   <= 1'b1;
      end else if (halt) begin
        stage_q   <= ST_FIRED;
        rst_req_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
  parameter int CTRL_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7,
  parameter int GRACE  = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                wr_en,
  input  logic [CTRL_W-1:0]   wr_data,
  output logic [CNT_W+2:0]    stat_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                nmi_o,
  output logic                rst_req_o
);
  logic           accept;
  logic           expire;
  logic           grace_ld;
  logic           halt;
  logic           run_q;
  logic [CNT_W:0] cnt_q;

  wdk_keygate #(.CTRL_W(CTRL_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .accept  (accept),
    .ctrl_q  (ctrl_o)
  );

  wdk_counter #(.CNT_W(CNT_W), .GRACE(GRACE)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_field (wr_data[CNT_W-1:0]),
    .load_run   (wr_data[CNT_W]),
    .tick_en    (tick_en),
    .grace_ld   (grace_ld),
    .halt       (halt),
    .cnt_q      (cnt_q),
    .run_q      (run_q),
    .expire     (expire)
  );

  wdk_escalate u_esc (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .expire    (expire),
    .grace_ld  (grace_ld),
    .halt      (halt),
    .nmi_q     (nmi_o),
    .rst_req_q (rst_req_o)
  );

  assign stat_o = {nmi_o, run_q, cnt_q};
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int CTRL_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7,
  parameter int GRACE  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CNT_W+2:0]  stat_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              nmi_o,
  input logic              rst_req_o
);
  localparam int KEY_LSB = CNT_W + 1;
  localparam logic [CNT_W:0] GRACE_V = (CNT_W+1)'(GRACE);

  logic key_match;
  logic armed;
  assign key_match = (wr_data[KEY_LSB +: KEY_W] == ~ctrl_o[KEY_LSB +: KEY_W]);
  assign armed     = ctrl_o[CNT_W];

  // R8: the reset request lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  // R8: a reset request is only issued after the interrupt stage
  a_r8_after_nmi: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(nmi_o));

  // R7: when the interrupt rises the grace count is loaded
  a_r7_grace_load: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_o) |-> (stat_o[CNT_W:0] == GRACE_V));

  // R3: a mis-keyed write while armed with no tick changes nothing
  a_r3_bad_key_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && armed && !key_match && !tick_en) |=> ($stable(stat_o) && $stable(ctrl_o)));

  // R9: an accepted write clears the interrupt
  a_r9_clear_nmi: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (!armed || key_match)) |=> !nmi_o);

  // R5: a stopped counter only moves on a write
  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!stat_o[CNT_W+1] && !wr_en) |=> $stable(stat_o[CNT_W:0]));
endmodule

bind wdk_top wdk_checker #(.CTRL_W(CTRL_W), .CNT_W(CNT_W), .KEY_W(KEY_W), .GRACE(GRACE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .stat_o    (stat_o),
  .ctrl_o    (ctrl_o),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o)
);

// File: tb/test_wdk_top.sv
module test_wdk_top;
  localparam int GRACE = 1;

  typedef struct {
    string       tag;
    logic [10:0] stat;
    logic [31:0] ctrl;
    logic        nmi;
    logic        rq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [10:0] stat_o;
  logic [31:0] ctrl_o;
  logic        nmi_o;
  logic        rst_req_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  // reference state, built from the requirements
  logic [31:0] m_ctrl;
  int          m_cnt;
  bit          m_run, m_nmi, m_rq;

  always #4 clk = ~clk;

  wdk_top #(.GRACE(GRACE)) i_wdk_top (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .stat_o(stat_o), .ctrl_o(ctrl_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] word(input int key, input bit run, input int cnt);
    return {16'h0, key[6:0], run, cnt[7:0]};
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag  = tag;
    e.stat = {m_nmi, m_run, m_cnt[8:0]};
    e.ctrl = m_ctrl;
    e.nmi  = m_nmi;
    e.rq   = m_rq;
    sb.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    @(posedge clk); #2;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    m_ctrl = '0; m_cnt = 0; m_run = 0; m_nmi = 0; m_rq = 0;
    push(tag);
  endtask

  // one clock of stimulus, then the expected post-edge state
  task automatic step(input bit wr, input logic [31:0] d, input bit tk, input string tag);
    bit acc;
    @(posedge clk); #2;
    wr_en = wr; wr_data = d; tick_en = tk;
    @(posedge clk); #2;
    wr_en = 1'b0; tick_en = 1'b0;
    acc  = wr && (!m_ctrl[8] || (d[15:9] == ~m_ctrl[15:9]));
    m_rq = 0;
    if (acc) begin
      m_ctrl = d;
      m_cnt  = (d[7:0] == 0) ? 256 : int'(d[7:0]);
      m_run  = d[8];
      m_nmi  = 0;
    end else if (tk && m_run) begin
      if (m_cnt == 1) begin
        if (!m_nmi) begin
          m_nmi = 1; m_cnt = GRACE;
        end else begin
          m_rq = 1; m_run = 0; m_cnt = 0;
        end
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    push(tag);
  endtask

  // monitor: compares results as they appear
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (stat_o !== e.stat || ctrl_o !== e.ctrl || nmi_o !== e.nmi || rst_req_o !== e.rq) begin
        n_fail++;
        $display("FAIL %s: stat=%h ctrl=%h nmi=%b rq=%b expected stat=%h ctrl=%h nmi=%b rq=%b",
                 e.tag, stat_o, ctrl_o, nmi_o, rst_req_o, e.stat, e.ctrl, e.nmi, e.rq);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    step(0, '0, 1, "R5 tick while stopped after reset");
    step(1, word(7'h2A, 1, 3), 0, "R2 disabled accepts any key");
    step(0, '0, 1, "R6 tick decrements");
    step(0, '0, 0, "R6 no tick holds");
    step(1, word(7'h2A, 1, 9), 0, "R3 repeated key ignored");
    step(1, word(7'h13, 0, 9), 1, "R3 wrong key ignored, tick still counts");
    step(1, word(7'h55, 1, 0), 0, "R4 zero count loads 256");
    step(0, '0, 1, "R6 tick from 256");
    step(1, word(7'h2A, 1, 2), 0, "R4 alternated key reload");
    step(0, '0, 1, "R6 tick to 1");
    step(0, '0, 1, "R7 first expiry raises nmi with grace");
    step(0, '0, 0, "R7 nmi held, still running");
    step(0, '0, 1, "R8 second expiry requests reset");
    step(0, '0, 0, "R8 reset request drops after one cycle");
    step(0, '0, 1, "R8 halted counter ignores ticks");
    step(1, word(7'h55, 0, 5), 0, "R9 accepted write clears nmi; R5 stop");
    step(0, '0, 1, "R5 stopped counter holds");
    step(1, word(7'h11, 1, 2), 0, "R2 disarmed word accepts new key");
    step(0, '0, 1, "R6 tick to 1 again");
    step(0, '0, 1, "R7 expiry again after history cleared");
    step(1, word(7'h6E, 1, 4), 1, "R10 write beats tick; R9 nmi cleared");
    step(0, '0, 1, "R9 history clear, count resumes");
    step(0, '0, 1, "R6 tick to 2");
    step(0, '0, 1, "R6 tick to 1");
    step(0, '0, 1, "R9 next expiry is first stage again");
    do_reset("R1 reset mid escalation");
    step(1, word(7'h00, 1, 1), 0, "R2 after reset any key");
    step(0, '0, 1, "R7 single-count expiry");
    @(posedge clk); @(negedge clk); #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule